// File: doc/BRIEF.md
# Floating-point status and exception controller

This block holds the status/control word of a floating-point unit. Software loads the word through a masked write port. The stored fields drive two controls for the arithmetic datapath: a truncation-rounding select and a flush-to-zero enable.

Each time the datapath finishes an operation, it pulses a completion strobe and presents five IEEE exception flags. On that strobe the block replaces the per-operation cause field with the flags it received. It ORs those flags into a sticky flag field. If any cause bit is enabled, it raises a one-cycle exception request carrying a fixed vector code.

Operations marked as approximate report inexact when they raise no other flag.

The word layout is as follows:
- Rounding mode: bits 1:0.
- Sticky flags: bits 6:2.
- Enables: bits 11:7.
- Causes: bits 16:12.
- Denormal-handling bit: bit 18.

Within each five-bit field the order from the low bit up is inexact, underflow, overflow, divide-by-zero, invalid. The `op_flags` input uses the same order.

Top module: `fpu_status_ctl`

## Requirements
- R1: After reset the status word is zero, `exc_req` is 0, `exc_code` is 0, and both control outputs are 0.
- R2: A write stores `wr_data & 32'h0005_FFFF`. Bits outside that mask always read as zero.
- R3: `round_trunc` is 1 exactly when status bits 1:0 equal 2'b01. The other encodings (00, 10, 11) give 0, which means round-to-nearest-even.
- R4: `flush_zero` equals status bit 18.
- R5: The cause field on a completion is replaced, not accumulated. After a completion, bits 16:12 equal the effective flags of that operation, and earlier cause bits are cleared.
- R6: A completion ORs its effective flags into bits 6:2. A completion never clears a sticky flag bit.
- R7: In the cycle after a completion whose effective flags AND the enable field (bits 11:7) is nonzero, `exc_req` is 1 for one cycle. Otherwise it is 0. `exc_code` is 12'h120 while `exc_req` is 1 and 0 otherwise.
- R8: For a completion with `op_approx` = 1 and `op_flags` = 0, the effective flags are 5'b00001 (inexact). If any flag is raised, the effective flags are `op_flags` unchanged.
- R9: With neither a write nor a completion, the status word holds its value.
- R10: A write and a completion in the same cycle apply the write first. The completion then updates the causes and flags of the written value, and tests the written enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Value to write (masked) |
| op_done | input | 1 | Operation completion strobe |
| op_approx | input | 1 | Completing operation is approximate |
| op_flags | input | 5 | Exception flags of the completing operation |
| status | output | 32 | Current status word |
| round_trunc | output | 1 | 1 selects truncation rounding, 0 selects nearest-even |
| flush_zero | output | 1 | Flush-to-zero enable |
| exc_req | output | 1 | One-cycle exception request |
| exc_code | output | 12 | Vector code of the request |

## Verification
The whole word is visible on `status`, so a wrong cause, flag or enable bit shows there one cycle after the write or completion that produced it. The same bit corrupts the `exc_req` decision on the next completion. A bad rounding or denormal field reaches `round_trunc` or `flush_zero` in that same cycle, because those outputs are decoded combinationally from the register. Random writes and completions, including same-cycle collisions and approximate operations with and without flags, are compared against a bench model on every cycle.

// File: rtl/fpu_status_ctl.sv
module fpu_status_ctl #(
  parameter int          XW       = 32,
  parameter logic [31:0] WMASK    = 32'h0005_FFFF,
  parameter logic [11:0] TRAP_VEC = 12'h120,
  parameter logic [1:0]  RM_TRUNC = 2'b01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          op_done,
  input  logic          op_approx,
  input  logic [4:0]    op_flags,
  output logic [31:0]   status,
  output logic          round_trunc,
  output logic          flush_zero,
  output logic          exc_req,
  output logic [11:0]   exc_code
);
  localparam int NX     = 5;
  localparam int FLG_LO = 2;
  localparam int EN_LO  = FLG_LO + NX;
  localparam int CAU_LO = EN_LO + NX;
  localparam int DN_BIT = CAU_LO + NX + 1;

  logic [XW-1:0] stat_q, base, nxt;
  logic [NX-1:0] eff;
  logic          trap_q, trap_nxt;

  assign eff = (op_approx && op_flags == '0) ? NX'(1) : op_flags;

  always_comb begin
    base     = wr_en ? (wr_data & WMASK) : stat_q;
    nxt      = base;
    trap_nxt = 1'b0;
    if (op_done) begin
      nxt[CAU_LO +: NX] = eff;
      nxt[FLG_LO +: NX] = base[FLG_LO +: NX] | eff;
      trap_nxt          = |(eff & base[EN_LO +: NX]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      trap_q <= 1'b0;
    end else begin
      stat_q <= nxt;
      trap_q <= trap_nxt;
    end
  end

  assign status      = stat_q;
  assign round_trunc = (stat_q[1:0] == RM_TRUNC);
  assign flush_zero  = stat_q[DN_BIT];
  assign exc_req     = trap_q;
  assign exc_code    = trap_q ? TRAP_VEC : 12'h000;
endmodule

module fpu_status_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        op_done,
  input logic        op_approx,
  input logic [4:0]  op_flags,
  input logic [31:0] status,
  input logic        round_trunc,
  input logic        flush_zero,
  input logic        exc_req,
  input logic [11:0] exc_code
);
  a_r2_mask_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~32'h0005_FFFF) == 32'h0);
  a_r3_trunc_decode: assert property (@(posedge clk) disable iff (!rst_n)
    round_trunc == (status[1:0] == 2'b01));
  a_r4_flush_bit: assert property (@(posedge clk) disable iff (!rst_n)
    flush_zero == status[18]);
  a_r5_cause_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && !op_approx |=> status[16:12] == $past(op_flags));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && !wr_en |=> (status[6:2] & $past(status[6:2])) == $past(status[6:2]));
  a_r7_code_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> exc_code == 12'h120);
  a_r7_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> exc_code == 12'h000);
  a_r7_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (status[16:12] & status[11:7]) != 5'd0);
  a_r7_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> !exc_req);
  a_r8_inject: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && op_approx && op_flags == 5'd0 |=> status[16:12] == 5'b00001);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done && !wr_en |=> $stable(status));
endmodule

bind fpu_status_ctl fpu_status_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_done(op_done),
  .op_approx(op_approx), .op_flags(op_flags), .status(status),
  .round_trunc(round_trunc), .flush_zero(flush_zero),
  .exc_req(exc_req), .exc_code(exc_code));

// File: tb/sim_fpu_status_ctl.sv
module sim_fpu_status_ctl;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, op_done = 1'b0, op_approx = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0] op_flags = '0;
  logic [31:0] status;
  logic round_trunc, flush_zero, exc_req;
  logic [11:0] exc_code;

  int checks = 0, errors = 0;
  logic [31:0] m_stat = '0;
  logic m_req = 1'b0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  fpu_status_ctl u0 (.*);

  function automatic logic [4:0] eff_f(logic ap, logic [4:0] fl);
    return (ap && fl == 5'd0) ? 5'b00001 : fl;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [31:0] wd, logic dn, logic ap, logic [4:0] fl);
    logic [31:0] b;
    logic [4:0] e;
    wr_en = we; wr_data = wd; op_done = dn; op_approx = ap; op_flags = fl;
    b = we ? (wd & 32'h0005_FFFF) : m_stat;
    e = eff_f(ap, fl);
    m_req = 1'b0;
    if (dn) begin
      b[16:12] = e;
      b[6:2] = b[6:2] | e;
      m_req = |(e & b[11:7]);
    end
    m_stat = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0; op_approx = 1'b0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " status"}, status, m_stat);
    chk("R3 round_trunc", {31'd0, round_trunc}, {31'd0, m_stat[1:0] == 2'b01});
    chk("R4 flush_zero", {31'd0, flush_zero}, {31'd0, m_stat[18]});
    chk("R7 exc_req", {31'd0, exc_req}, {31'd0, m_req});
    chk("R7 exc_code", {20'd0, exc_code}, m_req ? 32'h120 : 32'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset status", status, 32'h0);
    chk("R1 reset req", {31'd0, exc_req}, 32'h0);
    chk("R1 reset code", {20'd0, exc_code}, 32'h0);
    chk("R1 reset ctl", {30'd0, round_trunc, flush_zero}, 32'h0);
    step(1, 32'hFFFF_FFFF, 0, 0, 0); check_all("R2 mask");
    for (int r = 0; r < 4; r++) begin
      step(1, 32'(r), 0, 0, 0); check_all("R3 rm");
    end
    step(1, 32'h0004_0000, 0, 0, 0); check_all("R4 denorm");
    step(0, 0, 0, 0, 0); check_all("R9 hold");
    step(1, 32'h0000_0F80 | 32'h0001_F000, 0, 0, 0); check_all("R2 en");
    step(0, 0, 1, 0, 5'b00100); check_all("R5 replace");
    step(0, 0, 1, 0, 5'b00000); check_all("R6 sticky");
    step(0, 0, 1, 1, 5'b00000); check_all("R8 inject");
    step(0, 0, 1, 1, 5'b10000); check_all("R8 suppress");
    step(1, 32'h0000_0080, 1, 0, 5'b00001); check_all("R10 collide");
    step(1, 32'h0000_0000, 1, 0, 5'b11111); check_all("R10 no enable");
    for (int i = 0; i < 600; i++) begin
      logic we, dn, ap;
      logic [4:0] fl;
      we = ($urandom % 4) == 0;
      dn = ($urandom % 2) == 0;
      ap = ($urandom % 4) == 0;
      fl = (($urandom % 3) == 0) ? 5'd0 : 5'($urandom);
      step(we, $urandom, dn, ap, fl);
      check_all(dn ? "R5 R6 rand" : "R9 rand");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule